// File: doc/BRIEF.md
# Accumulator-based 16-bit stored-program processor

This block is a minimal processor that runs a program held in one external word-addressed memory. It holds a 12-bit program counter, a 16-bit accumulator and a 16-bit instruction register. A single arithmetic unit performs the data operations and also forms the next instruction address. Each instruction word carries a 4-bit opcode in bits 15:12 and a 12-bit operand address S in bits 11:0. Eight opcodes are defined: load, store, add, subtract, an unconditional jump, a jump taken when the accumulator is not negative, a jump taken when it is nonzero, and stop.

Timing is set by the memory: an instruction takes exactly as many clock cycles as it makes memory accesses. One phase bit selects between executing the instruction in the register and fetching after an operand access. Load, store, add and subtract spend one cycle on the operand at S and one cycle fetching the next instruction. A jump folds its decision into the fetch, so it completes in a single cycle. Stop leaves the memory idle and raises a halted flag until the next reset.

The memory is asynchronous-read: read data must be valid in the same cycle as the address and request. A write is taken on the rising edge when the request is high and the read-not-write line is low. Reset is synchronous and active high.

Top module: `accu_cpu`

## Requirements
- R1: While reset is high for at least one rising edge, the accumulator is cleared, so the write-data port reads 0. The first cycle after reset is released is a memory read of address 0.
- R2: Load (opcode 0), add (opcode 2) and subtract (opcode 3) each read memory at S in the cycle after their fetch. The accumulator becomes mem[S], ACC+mem[S] or ACC−mem[S] respectively, wrapping modulo 2^16.
- R3: Store (opcode 1) makes one write cycle at address S with read-not-write low and the accumulator on the write-data port. The accumulator does not change.
- R4: Opcodes 0 to 3 take two cycles each, an operand access followed by a fetch at the program counter. The memory request is high in every cycle until the processor halts.
- R5: The unconditional jump (opcode 4) fetches from S in its single cycle, and the program counter becomes S+1.
- R6: The jump of opcode 5 is taken exactly when accumulator bit 15 is 0.
- R7: The jump of opcode 6 is taken exactly when the accumulator is nonzero.
- R8: A conditional jump that is not taken fetches the next sequential address in its single cycle and goes on from there.
- R9: Stop (opcode 7) raises the halted output and drops the memory request. From then until reset, the accumulator, the program counter and the memory stay unchanged.
- R10: Opcodes 8 to 15 behave exactly like stop.
- R11: The write-data port always shows the current accumulator. Read-not-write is low only in a store's operand cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| memAddr | output | 12 | Word address to memory |
| memRdData | input | 16 | Read data, valid in the same cycle as the address |
| memWrData | output | 16 | Write data; always the accumulator |
| memReq | output | 1 | Memory access request |
| memRdNotWr | output | 1 | High for a read, low for a write |
| halted | output | 1 | High while the processor is stopped |

## Verification
The bench compares every bus cycle against an instruction-level model. This exposes a store that leaves the accumulator changed, a memory instruction that takes one or three cycles, and a jump that takes an extra fetch cycle. It drives the accumulator to 0x8000, 0 and 0xFFFF before conditional jumps and arithmetic. A sign test on the wrong bit, or a zero test inverted, sends execution down the wrong path and shows up as a wrong fetch address. Add and subtract are checked across the 16-bit wrap. An unused opcode and a stop placed first in the program check that the processor goes quiet, rather than carrying on or writing memory after it stops.

// File: rtl/accu_cpu_pkg.sv
package accu_cpu_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int OPC_W = 4;

  typedef enum logic [2:0] {
    ALU_ZERO   = 3'd0,
    ALU_PASS_B = 3'd1,
    ALU_INC_B  = 3'd2,
    ALU_ADD    = 3'd3,
    ALU_SUB    = 3'd4
  } aluFn_e;

  typedef enum logic [OPC_W-1:0] {
    OP_LOAD      = 4'd0,
    OP_STORE     = 4'd1,
    OP_ADD       = 4'd2,
    OP_SUB       = 4'd3,
    OP_JUMP      = 4'd4,
    OP_JUMP_NNEG = 4'd5,
    OP_JUMP_NZ   = 4'd6,
    OP_HALT      = 4'd7
  } opcode_e;

  typedef struct packed {
    logic   addrFromIr;  // address mux: 1 = IR operand field, 0 = PC
    logic   bFromAddr;   // ALU B mux: 1 = selected address, 0 = read data
    aluFn_e aluFn;
    logic   accEn;
    logic   pcEn;
    logic   irEn;
    logic   irClear;
    logic   memReq;
    logic   rdNotWr;
  } strobes_t;

  localparam strobes_t STROBES_IDLE = '{
    addrFromIr: 1'b0, bFromAddr: 1'b0, aluFn: ALU_ZERO,
    accEn: 1'b0, pcEn: 1'b0, irEn: 1'b0, irClear: 1'b0,
    memReq: 1'b0, rdNotWr: 1'b1
  };
endpackage

// File: rtl/accu_alu.sv
module accu_alu
  import accu_cpu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  aluFn_e            fn,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  timeunit 1ns;
  timeprecision 1ps;

  always_comb begin
    unique case (fn)
      ALU_PASS_B: y = b;
      ALU_INC_B:  y = b + DATA_W'(1);
      ALU_ADD:    y = a + b;
      ALU_SUB:    y = a - b;
      default:    y = '0;
    endcase
  end
endmodule

// File: rtl/accu_dpath.sv
module accu_dpath
  import accu_cpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  strobes_t          st,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wrData,
  output logic [OPC_W-1:0]  opcode,
  output logic              accZero,
  output logic              accNeg
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int EXT_W = DATA_W - ADDR_W;

  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] ir;
  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] addrMux;
  logic [DATA_W-1:0] aluB;
  logic [DATA_W-1:0] aluY;

  assign addrMux = st.addrFromIr ? ir[ADDR_W-1:0] : pc;
  assign aluB    = st.bFromAddr ? {{EXT_W{1'b0}}, addrMux} : rdData;

  accu_alu #(.DATA_W(DATA_W)) u_alu (
    .fn (st.aluFn),
    .a  (acc),
    .b  (aluB),
    .y  (aluY)
  );

  always_ff @(posedge clk) begin
    if (st.accEn) acc <= aluY;
    if (st.pcEn)  pc  <= aluY[ADDR_W-1:0];
    if (st.irClear)   ir <= '0;
    else if (st.irEn) ir <= rdData;
  end

  assign addr    = addrMux;
  assign wrData  = acc;
  assign opcode  = ir[DATA_W-1 -: OPC_W];
  assign accZero = (acc == '0);
  assign accNeg  = acc[DATA_W-1];

  // R3: a write cycle leaves the accumulator as it was
  a_r3_store_keeps_acc: assert property (@(posedge clk) disable iff (rst)
    (st.memReq && !st.rdNotWr) |=> (acc == $past(acc)));

  // R2: a load puts the read word into the accumulator
  a_r2_load_value: assert property (@(posedge clk) disable iff (rst)
    (st.accEn && st.aluFn == ALU_PASS_B && !st.bFromAddr) |=> (acc == $past(rdData)));

  // R2: add accumulates modulo the word width
  a_r2_add_value: assert property (@(posedge clk) disable iff (rst)
    (st.accEn && st.aluFn == ALU_ADD) |=> (acc == DATA_W'($past(acc) + $past(rdData))));

  // R5: a fetch from the operand field leaves PC one past the target
  a_r5_jump_pc: assert property (@(posedge clk) disable iff (rst)
    (st.addrFromIr && st.irEn) |=> (pc == ADDR_W'($past(ir[ADDR_W-1:0]) + 1'b1)));
endmodule

// File: rtl/accu_ctrl.sv
module accu_ctrl
  import accu_cpu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  input  logic             accZero,
  input  logic             accNeg,
  output strobes_t         st,
  output logic             halted
);
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic {ST_EXEC = 1'b0, ST_FETCH = 1'b1} phase_e;

  phase_e phase;
  phase_e phaseNext;
  logic   isJump;
  logic   takeJump;

  function automatic strobes_t fetch_strobes(input logic fromIr);
    strobes_t s;
    s            = STROBES_IDLE;
    s.addrFromIr = fromIr;
    s.bFromAddr  = 1'b1;
    s.aluFn      = ALU_INC_B;
    s.pcEn       = 1'b1;
    s.irEn       = 1'b1;
    s.memReq     = 1'b1;
    return s;
  endfunction

  always_comb begin
    isJump   = 1'b0;
    takeJump = 1'b0;
    case (opcode_e'(opcode))
      OP_JUMP:      begin isJump = 1'b1; takeJump = 1'b1;     end
      OP_JUMP_NNEG: begin isJump = 1'b1; takeJump = !accNeg;  end
      OP_JUMP_NZ:   begin isJump = 1'b1; takeJump = !accZero; end
      default:      begin isJump = 1'b0; takeJump = 1'b0;     end
    endcase
  end

  always_comb begin
    st        = STROBES_IDLE;
    phaseNext = phase;
    halted    = 1'b0;
    if (rst) begin
      st.aluFn   = ALU_ZERO;
      st.accEn   = 1'b1;
      st.pcEn    = 1'b1;
      st.irClear = 1'b1;
      st.memReq  = 1'b1;
      phaseNext  = ST_FETCH;
    end else if (phase == ST_FETCH) begin
      st        = fetch_strobes(1'b0);
      phaseNext = ST_EXEC;
    end else if (isJump) begin
      st = fetch_strobes(takeJump);
    end else begin
      case (opcode_e'(opcode))
        OP_LOAD, OP_ADD, OP_SUB: begin
          st.addrFromIr = 1'b1;
          st.accEn      = 1'b1;
          st.memReq     = 1'b1;
          case (opcode_e'(opcode))
            OP_ADD:  st.aluFn = ALU_ADD;
            OP_SUB:  st.aluFn = ALU_SUB;
            default: st.aluFn = ALU_PASS_B;
          endcase
          phaseNext = ST_FETCH;
        end
        OP_STORE: begin
          st.addrFromIr = 1'b1;
          st.aluFn      = ALU_PASS_B;
          st.memReq     = 1'b1;
          st.rdNotWr    = 1'b0;
          phaseNext     = ST_FETCH;
        end
        default: halted = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    phase <= phaseNext;
  end

  // R4: every cycle before the halt is a memory access
  a_r4_running_access: assert property (@(posedge clk) disable iff (rst)
    !halted |-> st.memReq);

  // R4: an operand access is always followed by a fetch cycle
  a_r4_operand_then_fetch: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_EXEC && st.memReq && !isJump) |=> (phase == ST_FETCH));

  // R9: while halted nothing is enabled and memory is idle
  a_r9_halt_quiet: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!st.memReq && !st.accEn && !st.pcEn && !st.irEn));

  // R9: the halt persists until reset
  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R11: a write only ever uses the operand address
  a_r11_write_in_operand: assert property (@(posedge clk) disable iff (rst)
    !st.rdNotWr |-> (phase == ST_EXEC && st.addrFromIr && st.memReq));
endmodule

// File: rtl/accu_cpu.sv
module accu_cpu
  import accu_cpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DATA_W-1:0] memWrData,
  output logic              memReq,
  output logic              memRdNotWr,
  output logic              halted
);
  timeunit 1ns;
  timeprecision 1ps;

  strobes_t         st;
  logic [OPC_W-1:0] opcode;
  logic             accZero;
  logic             accNeg;

  accu_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .opcode  (opcode),
    .accZero (accZero),
    .accNeg  (accNeg),
    .st      (st),
    .halted  (halted)
  );

  accu_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk     (clk),
    .rst     (rst),
    .st      (st),
    .rdData  (memRdData),
    .addr    (memAddr),
    .wrData  (memWrData),
    .opcode  (opcode),
    .accZero (accZero),
    .accNeg  (accNeg)
  );

  assign memReq     = st.memReq;
  assign memRdNotWr = st.rdNotWr;

  // R1: the first cycle after reset reads address zero
  a_r1_start_at_zero: assert property (@(posedge clk)
    $fell(rst) |-> (memAddr == '0 && memReq && memRdNotWr && !halted));
endmodule

// File: tb/accu_cpu_bench.sv
module accu_cpu_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DATA_W    = 16;
  localparam int ADDR_W    = 12;
  localparam int MEM_AW    = 9;
  localparam int MEM_W     = 1 << MEM_AW;
  localparam int DATA_BASE = 256;
  localparam int DATA_N    = 16;
  localparam int MAX_CYC   = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memRdData;
  logic [DATA_W-1:0] memWrData;
  logic memReq, memRdNotWr, halted;

  logic [DATA_W-1:0] mem [MEM_W];
  logic [DATA_W-1:0] img [MEM_W];
  logic [DATA_W-1:0] mm  [MEM_W];
  logic copyImg = 1'b0;

  logic [ADDR_W-1:0] expAddr [MAX_CYC];
  logic              expRd   [MAX_CYC];
  logic [DATA_W-1:0] expWd   [MAX_CYC];
  string             expTag  [MAX_CYC];
  int                expN;
  logic [DATA_W-1:0] finalAcc;
  string             haltTag;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  accu_cpu u_accu_cpu (
    .clk        (clk),
    .rst        (rst),
    .memAddr    (memAddr),
    .memRdData  (memRdData),
    .memWrData  (memWrData),
    .memReq     (memReq),
    .memRdNotWr (memRdNotWr),
    .halted     (halted)
  );

  assign memRdData = mem[memAddr[MEM_AW-1:0]];

  always @(posedge clk) begin
    if (copyImg) begin
      for (int i = 0; i < MEM_W; i++) mem[i] <= img[i];
    end else if (memReq && !memRdNotWr) begin
      mem[memAddr[MEM_AW-1:0]] <= memWrData;
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] ins(input int op, input int s);
    return {4'(op), 12'(s)};
  endfunction

  task automatic clear_img();
    for (int i = 0; i < MEM_W; i++) img[i] = '0;
  endtask

  task automatic put(input logic [ADDR_W-1:0] a, input logic rd, input logic [DATA_W-1:0] wd, input string tag);
    expAddr[expN] = a;
    expRd[expN]   = rd;
    expWd[expN]   = wd;
    expTag[expN]  = tag;
    expN++;
  endtask

  // Instruction-level model producing the expected bus cycle list
  task automatic run_model();
    logic [DATA_W-1:0] acc, ir;
    logic [ADDR_W-1:0] pc, s, a;
    logic [3:0] op;
    logic take;
    for (int i = 0; i < MEM_W; i++) mm[i] = img[i];
    expN = 0; acc = '0; pc = '0;
    put(pc, 1'b1, acc, "R1");
    ir = mm[pc[MEM_AW-1:0]]; pc = pc + 1'b1;
    haltTag = "R9";
    while (expN < MAX_CYC - 3) begin
      op = ir[15:12]; s = ir[11:0];
      if (op <= 4'd3) begin
        if (op == 4'd1) begin
          put(s, 1'b0, acc, "R3");
          mm[s[MEM_AW-1:0]] = acc;
        end else begin
          put(s, 1'b1, acc, "R2");
          if (op == 4'd0)      acc = mm[s[MEM_AW-1:0]];
          else if (op == 4'd2) acc = acc + mm[s[MEM_AW-1:0]];
          else                 acc = acc - mm[s[MEM_AW-1:0]];
        end
        put(pc, 1'b1, acc, "R4");
        ir = mm[pc[MEM_AW-1:0]]; pc = pc + 1'b1;
      end else if (op <= 4'd6) begin
        take = (op == 4'd4) || (op == 4'd5 && !acc[15]) || (op == 4'd6 && acc != '0);
        a = take ? s : pc;
        if (!take)          put(a, 1'b1, acc, "R8");
        else if (op == 4'd4) put(a, 1'b1, acc, "R5");
        else if (op == 4'd5) put(a, 1'b1, acc, "R6");
        else                 put(a, 1'b1, acc, "R7");
        ir = mm[a[MEM_AW-1:0]]; pc = a + 1'b1;
      end else begin
        if (op >= 4'd8) haltTag = "R10";
        break;
      end
    end
    finalAcc = acc;
  endtask

  task automatic run_prog();
    logic [DATA_W-1:0] heldAcc;
    int bad;
    run_model();
    @(negedge clk); rst = 1'b1; copyImg = 1'b1;
    @(negedge clk); copyImg = 1'b0;
    @(negedge clk);
    chk("R1", "acc in reset", memWrData, 0);
    chk("R1", "halted in reset", halted, 0);
    rst = 1'b0;
    #1;
    for (int k = 0; k <= expN; k++) begin
      if (k > 0) begin @(posedge clk); @(negedge clk); end
      if (k < expN) begin
        chk(expTag[k], "running", {halted, memReq}, 2'b01);
        chk(expTag[k], "address", memAddr, expAddr[k]);
        chk("R11", "rdNotWr", memRdNotWr, expRd[k]);
        chk("R11", "acc on write bus", memWrData, expWd[k]);
      end else begin
        chk(haltTag, "halt entry", {halted, memReq}, 2'b10);
      end
    end
    heldAcc = memWrData;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(haltTag, "halt held", {halted, memReq}, 2'b10);
    chk(haltTag, "acc frozen", memWrData, heldAcc);
    chk("R2", "final acc", memWrData, finalAcc);
    bad = 0;
    for (int i = 0; i < MEM_W; i++) if (mem[i] !== mm[i]) bad++;
    chk("R3", "memory mismatches", bad, 0);
  endtask

  task automatic build_random(input int n);
    int r, op, s;
    clear_img();
    for (int i = 0; i < DATA_N; i++) begin
      r = $urandom_range(0, 5);
      if (r == 0)      img[DATA_BASE + i] = 16'h0000;
      else if (r == 1) img[DATA_BASE + i] = 16'h8000;
      else if (r == 2) img[DATA_BASE + i] = 16'hFFFF;
      else             img[DATA_BASE + i] = 16'($urandom);
    end
    for (int p = 0; p < n - 1; p++) begin
      r = $urandom_range(0, 9);
      if (r < 7) begin
        op = r % 4;
        s  = DATA_BASE + $urandom_range(0, DATA_N - 1);
      end else begin
        op = 4 + (r - 7);
        s  = $urandom_range(p + 1, n - 1);
      end
      img[p] = ins(op, s);
    end
    img[n - 1] = ($urandom_range(0, 3) == 0) ? ins($urandom_range(8, 15), 0) : ins(7, 0);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seedv;
    seedv = $urandom(32'd8675309);

    // Load, subtract, store, taken non-negative jump, add, store
    clear_img();
    img[0] = ins(0, 'h100); img[1] = ins(3, 'h101); img[2] = ins(1, 'h102);
    img[3] = ins(5, 5);     img[4] = ins(7, 0);     img[5] = ins(2, 'h100);
    img[6] = ins(1, 'h103); img[7] = ins(7, 0);
    img['h100] = 16'h0007; img['h101] = 16'h0003;
    run_prog();
    chk("R6", "taken path result", mem['h103], 16'h000B);
    chk("R4", "cycles for program", expN, 12);

    // Negative accumulator: non-negative jump falls through
    clear_img();
    img[0] = ins(0, 'h100); img[1] = ins(5, 4); img[2] = ins(1, 'h101);
    img[3] = ins(7, 0);     img[4] = ins(1, 'h102); img[5] = ins(7, 0);
    img['h100] = 16'h8000;
    run_prog();
    chk("R8", "fall-through store", mem['h101], 16'h8000);
    chk("R6", "skipped store", mem['h102], 16'h0000);

    // Zero then nonzero accumulator before nonzero jump
    clear_img();
    img[0] = ins(0, 'h100); img[1] = ins(6, 5); img[2] = ins(0, 'h101);
    img[3] = ins(6, 6);     img[4] = ins(7, 0); img[5] = ins(7, 0);
    img[6] = ins(1, 'h102); img[7] = ins(7, 0);
    img['h100] = 16'h0000; img['h101] = 16'h1234;
    run_prog();
    chk("R7", "nonzero jump taken", mem['h102], 16'h1234);

    // Wrap-around on add and subtract
    clear_img();
    img[0] = ins(0, 'h100); img[1] = ins(2, 'h101); img[2] = ins(1, 'h102);
    img[3] = ins(3, 'h101); img[4] = ins(1, 'h103); img[5] = ins(7, 0);
    img['h100] = 16'hFFFF; img['h101] = 16'h0001; img['h102] = 16'h5555;
    run_prog();
    chk("R2", "add wraps", mem['h102], 16'h0000);
    chk("R2", "sub wraps", mem['h103], 16'hFFFF);

    // Unconditional jump over a store
    clear_img();
    img[0] = ins(0, 'h100); img[1] = ins(4, 4); img[2] = ins(1, 'h101);
    img[3] = ins(7, 0);     img[4] = ins(1, 'h102); img[5] = ins(7, 0);
    img['h100] = 16'h2222;
    run_prog();
    chk("R5", "jump target store", mem['h102], 16'h2222);
    chk("R5", "skipped store", mem['h101], 16'h0000);

    // Unused opcode stops the machine before a store
    clear_img();
    img[0] = ins(0, 'h100); img[1] = ins(9, 'h101); img[2] = ins(1, 'h101);
    img[3] = ins(7, 0);
    img['h100] = 16'h5A5A;
    run_prog();
    chk("R10", "no store after unused opcode", mem['h101], 16'h0000);

    // Stop as the very first instruction
    clear_img();
    img[0] = ins(7, 0); img[1] = ins(1, 'h100);
    run_prog();
    chk("R9", "one cycle to halt", expN, 1);

    for (int t = 0; t < 40; t++) begin
      build_random($urandom_range(6, 24));
      run_prog();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule